// File: doc/BRIEF.md
# Windowed Watchdog Timer with Boot Configuration Byte

This block is a windowed watchdog timer. It counts ticks of a slow low-speed clock, given to it as a one-cycle enable on the system clock. Software must refresh it at the right time. A refresh that comes too early is an error, and so is a missing refresh. In either case the block raises a one-cycle watchdog reset.

The whole behaviour is fixed by one 8-bit configuration byte. The byte is captured once after reset and cannot change afterwards. It selects these things:
- the overflow period, from a sparse set of powers of two;
- the fraction of the period during which a refresh is accepted;
- whether the counter runs at all;
- whether low-power modes and a software request may withhold the count clock.

If the byte holds a forbidden value, the block raises a status flag. It then falls back to the longest period with the window fully open.

Top module: `wdw_top`

## Requirements
- R1: The configuration byte is sampled on the first rising clock edge after `rst_n` goes high. Later changes to `cfg_byte` have no effect until the next reset. The field layout is:
  - bit 0 is the clock-lock bit;
  - bits 3:1 are the period code;
  - bit 4 is the run enable;
  - bits 6:5 are the window code;
  - bit 7 is reserved and must be 0.
- R2: The period codes 0 to 7 select an overflow after 2^7, 2^8, 2^9, 2^10, 2^12, 2^14, 2^15 and 2^17 counted ticks.
- R3: When the counted ticks since the last clear reach the selected period, `wdt_reset` is high for exactly one cycle, in the cycle after that tick. The count then restarts from zero.
- R4: The window codes 0 to 3 open the refresh window for the last 25%, 50%, 75% or 100% of the period. A refresh while the count is at or above the window start clears the count to zero and raises no reset.
- R5: A refresh while the count is below the window start raises `wdt_reset` for one cycle and clears the count.
- R6: With the run enable at 0, the counter stays at zero. Ticks and refreshes have no effect, and `wdt_reset` never rises.
- R7: With the clock-lock bit at 0, ticks are not counted while `halt_mode`, `stop_mode` or `osc_stop_req` is high.
- R8: With the clock-lock bit at 1, `halt_mode`, `stop_mode` and `osc_stop_req` are ignored and every tick is counted.
- R9: The latched byte is illegal in two cases: bit 7 is 1, or the period code is 0 together with window code 0. In either case `cfg_illegal` is 1, and the block uses the 2^17 period with the 100% window. Otherwise `cfg_illegal` is 0.
- R10: While in reset, and until the configuration is sampled, `wdt_reset` and `cfg_illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lsclk_tick | input | 1 | One-cycle pulse per low-speed clock period |
| cfg_byte | input | 8 | Configuration byte, sampled once after reset |
| refresh | input | 1 | Refresh strobe from software |
| halt_mode | input | 1 | System is in halt mode |
| stop_mode | input | 1 | System is in stop mode |
| osc_stop_req | input | 1 | Software request to stop the low-speed clock |
| wdt_reset | output | 1 | One-cycle watchdog reset pulse |
| cfg_illegal | output | 1 | Latched configuration is illegal |

## Verification
The assertions check several things on every cycle:
- the count stays below the selected period;
- the count does not move unless a tick is accepted or a refresh arrives;
- a stopped watchdog stays at zero;
- a refresh lands on the correct side of the window start;
- with the clock lock set, every tick reaches the counter;
- no reset appears before the configuration is sampled.

The exact overflow tick for each period code, the per-window boundary, and the fallback for illegal bytes are shown only by the bench scenarios. So are the freezing of the byte after sampling and the gating under each low-power input.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    // Configuration byte layout, MSB first.
    typedef struct packed {
        logic       rsvd;      // bit 7, must be zero
        logic [1:0] win;       // bits 6:5, window code
        logic       run_en;    // bit 4, counter enable
        logic [2:0] per;       // bits 3:1, period code
        logic       clk_lock;  // bit 0, low-speed clock cannot be stopped
    } cfg_t;

    localparam logic [2:0] PER_FALLBACK = 3'd7;
    localparam logic [1:0] WIN_FULL     = 2'd3;

    // Exponent of the overflow period for each period code.
    function automatic logic [4:0] per_exp(input logic [2:0] code);
        logic [4:0] e;
        case (code)
            3'd0:    e = 5'd7;
            3'd1:    e = 5'd8;
            3'd2:    e = 5'd9;
            3'd3:    e = 5'd10;
            3'd4:    e = 5'd12;
            3'd5:    e = 5'd14;
            3'd6:    e = 5'd15;
            default: e = 5'd17;
        endcase
        return e;
    endfunction

    // A byte is illegal if its reserved bit is set, or if it pairs the
    // shortest period with the narrowest window.
    function automatic logic cfg_bad(input cfg_t c);
        return c.rsvd | ((c.per == 3'd0) & (c.win == 2'd0));
    endfunction

endpackage

// File: rtl/wdw_cfg_latch.sv
module wdw_cfg_latch
    import wdw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cfg_byte,
    output logic       loaded_o,
    output logic       run_o,
    output logic       clk_lock_o,
    output logic [2:0] per_o,
    output logic [1:0] win_o,
    output logic       illegal_o
);

    typedef struct packed {
        logic loaded;
        cfg_t cfg;
    } state_t;

    state_t st_d, st_q;
    logic   bad;

    always_comb begin
        st_d = st_q;
        if (!st_q.loaded) begin
            st_d.loaded = 1'b1;
            st_d.cfg    = cfg_t'(cfg_byte);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bad        = st_q.loaded & cfg_bad(st_q.cfg);
        loaded_o   = st_q.loaded;
        run_o      = st_q.loaded & st_q.cfg.run_en;
        clk_lock_o = st_q.cfg.clk_lock;
        per_o      = bad ? PER_FALLBACK : st_q.cfg.per;
        win_o      = bad ? WIN_FULL     : st_q.cfg.win;
        illegal_o  = bad;
    end

    // R1: once sampled, the configuration never changes until reset
    a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.loaded |=> $stable(st_q.cfg));

endmodule

// File: rtl/wdw_tick_gate.sv
module wdw_tick_gate (
    input  logic tick_i,
    input  logic run_i,
    input  logic clk_lock_i,
    input  logic halt_i,
    input  logic stop_i,
    input  logic stop_req_i,
    output logic tick_o
);

    logic withheld;

    always_comb begin
        // Without the lock, any low-power mode or a software stop request
        // takes the count clock away.
        withheld = ~clk_lock_i & (halt_i | stop_i | stop_req_i);
        tick_o   = tick_i & run_i & ~withheld;
    end

endmodule

// File: rtl/wdw_counter.sv
module wdw_counter
    import wdw_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       tick_i,
    input  logic       refresh_i,
    input  logic [2:0] per_i,
    input  logic [1:0] win_i,
    output logic       wdt_rst_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rst_pulse;
    } state_t;

    state_t           st_d, st_q;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] quarter;
    logic [CNT_W-1:0] win_start;
    logic             early;

    always_comb begin
        period  = CNT_W'(1) << per_exp(per_i);
        quarter = period >> 2;
        case (win_i)
            2'd0:    win_start = quarter + (quarter << 1);
            2'd1:    win_start = quarter << 1;
            2'd2:    win_start = quarter;
            default: win_start = '0;
        endcase
        early = st_q.cnt < win_start;
    end

    always_comb begin
        st_d           = st_q;
        st_d.rst_pulse = 1'b0;
        if (run_i && refresh_i) begin
            // A refresh always clears; an early one also fires the reset.
            st_d.cnt       = '0;
            st_d.rst_pulse = early;
        end else if (tick_i) begin
            if (st_q.cnt == period - CNT_W'(1)) begin
                st_d.cnt       = '0;
                st_d.rst_pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wdt_rst_o = st_q.rst_pulse;

    // R2: the count never reaches the selected period
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < period);

    // R5: a refresh in the closed window fires the reset
    a_r5_early_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && refresh_i && (st_q.cnt < win_start)) |=> st_q.rst_pulse);

    // R4: a refresh in the open window clears quietly
    a_r4_open_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && refresh_i && (st_q.cnt >= win_start))
            |=> (st_q.cnt == '0) && !st_q.rst_pulse);

    // R6: a stopped watchdog holds zero and stays quiet
    a_r6_stopped_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> (st_q.cnt == '0) && !st_q.rst_pulse);

    // R7: without an accepted tick or refresh the count holds
    a_r7_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !(run_i && refresh_i)) |=> $stable(st_q.cnt));

endmodule

// File: rtl/wdw_top.sv
module wdw_top #(
    parameter int CNT_W = 18   // must hold 2^17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lsclk_tick,
    input  logic [7:0] cfg_byte,
    input  logic       refresh,
    input  logic       halt_mode,
    input  logic       stop_mode,
    input  logic       osc_stop_req,
    output logic       wdt_reset,
    output logic       cfg_illegal
);

    logic       loaded;
    logic       run;
    logic       clk_lock;
    logic [2:0] per;
    logic [1:0] win;
    logic       cnt_tick;

    wdw_cfg_latch u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_byte   (cfg_byte),
        .loaded_o   (loaded),
        .run_o      (run),
        .clk_lock_o (clk_lock),
        .per_o      (per),
        .win_o      (win),
        .illegal_o  (cfg_illegal)
    );

    wdw_tick_gate u_gate (
        .tick_i     (lsclk_tick),
        .run_i      (run),
        .clk_lock_i (clk_lock),
        .halt_i     (halt_mode),
        .stop_i     (stop_mode),
        .stop_req_i (osc_stop_req),
        .tick_o     (cnt_tick)
    );

    wdw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .tick_i    (cnt_tick),
        .refresh_i (refresh),
        .per_i     (per),
        .win_i     (win),
        .wdt_rst_o (wdt_reset)
    );

    // R10: nothing is reported before the configuration is sampled
    a_r10_quiet_before_load: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded |-> !wdt_reset && !cfg_illegal);

    // R8: with the clock locked, every tick of a running watchdog counts
    a_r8_lock_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (run && clk_lock && lsclk_tick) |-> cnt_tick);

endmodule

// File: tb/wdw_top_bench.sv
`timescale 1ns/1ps
module wdw_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lsclk_tick = 1'b0;
    logic [7:0] cfg_byte = '0;
    logic       refresh = 1'b0;
    logic       halt_mode = 1'b0;
    logic       stop_mode = 1'b0;
    logic       osc_stop_req = 1'b0;
    logic       wdt_reset;
    logic       cfg_illegal;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    wdw_top u_wdw_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .lsclk_tick   (lsclk_tick),
        .cfg_byte     (cfg_byte),
        .refresh      (refresh),
        .halt_mode    (halt_mode),
        .stop_mode    (stop_mode),
        .osc_stop_req (osc_stop_req),
        .wdt_reset    (wdt_reset),
        .cfg_illegal  (cfg_illegal)
    );

    function automatic logic [7:0] mk_cfg(input logic rsvd, input logic [1:0] win,
                                          input logic en, input logic [2:0] per,
                                          input logic lock);
        return {rsvd, win, en, per, lock};
    endfunction

    function automatic int exp_period(input int code);
        int e[8] = '{7, 8, 9, 10, 12, 14, 15, 17};
        return 1 << e[code];
    endfunction

    function automatic int exp_win_start(input int code_per, input int code_win);
        return (exp_period(code_per) / 4) * (3 - code_win);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] cfg);
        @(negedge clk);
        rst_n = 1'b0;
        lsclk_tick = 1'b0; refresh = 1'b0;
        halt_mode = 1'b0; stop_mode = 1'b0; osc_stop_req = 1'b0;
        cfg_byte = cfg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Tick n times back to back; returns the 1-based tick index at which
    // wdt_reset was first seen, or 0 if never.
    task automatic tick_run(input int n, output int first);
        first = 0;
        for (int i = 1; i <= n; i++) begin
            lsclk_tick = 1'b1;
            @(negedge clk);
            if (wdt_reset && first == 0) first = i;
        end
        lsclk_tick = 1'b0;
    endtask

    task automatic do_refresh(output logic rst_seen);
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
        rst_seen = wdt_reset;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int   first;
        logic r;
        void'($urandom(32'd20251));

        // R10: reset state
        cfg_byte = mk_cfg(1'b1, 2'd0, 1'b1, 3'd0, 1'b1);
        repeat (3) @(negedge clk);
        check(!wdt_reset, "R10 reset wdt_reset", int'(wdt_reset), 0);
        check(!cfg_illegal, "R10 reset cfg_illegal", int'(cfg_illegal), 0);

        // R2 / R3: period sweep with the window fully open
        for (int c = 0; c < 7; c++) begin
            do_reset(mk_cfg(1'b0, 2'd3, 1'b1, 3'(c), 1'b1));
            check(!cfg_illegal, "R9 legal flag", int'(cfg_illegal), 0);
            tick_run(exp_period(c), first);
            check(first == exp_period(c), "R2 overflow tick", first, exp_period(c));
        end

        // R3: one-cycle pulse and restart
        do_reset(mk_cfg(1'b0, 2'd3, 1'b1, 3'd0, 1'b1));
        tick_run(128, first);
        check(first == 128, "R3 first overflow", first, 128);
        @(negedge clk);
        check(!wdt_reset, "R3 pulse width", int'(wdt_reset), 0);
        tick_run(128, first);
        check(first == 128, "R3 restart overflow", first, 128);

        // R4 / R5: directed window boundary, period 256 with the 25% window
        do_reset(mk_cfg(1'b0, 2'd0, 1'b1, 3'd1, 1'b1));
        tick_run(exp_win_start(1, 0) - 1, first);
        do_refresh(r);
        check(r == 1'b1, "R5 refresh one below window", int'(r), 1);
        tick_run(exp_win_start(1, 0), first);
        do_refresh(r);
        check(r == 1'b0, "R4 refresh at window start", int'(r), 0);
        tick_run(256, first);
        check(first == 256, "R4 cleared by refresh", first, 256);

        // R4 / R5: random configurations and refresh points
        for (int it = 0; it < 14; it++) begin
            int p  = int'($urandom % 4);
            int w  = int'($urandom % 4);
            int k;
            bit e;
            if (p == 0 && w == 0) w = 1;
            k = int'($urandom % exp_period(p));
            e = k < exp_win_start(p, w);
            do_reset(mk_cfg(1'b0, 2'(w), 1'b1, 3'(p), 1'b1));
            tick_run(k, first);
            check(first == 0, "R4 no reset before refresh", first, 0);
            do_refresh(r);
            check(r == e, e ? "R5 early refresh" : "R4 open refresh", int'(r), int'(e));
            tick_run(exp_period(p), first);
            check(first == exp_period(p), "R4 count cleared", first, exp_period(p));
        end

        // R6: disabled watchdog
        do_reset(mk_cfg(1'b0, 2'd1, 1'b0, 3'd0, 1'b1));
        tick_run(300, first);
        check(first == 0, "R6 ticks ignored", first, 0);
        do_refresh(r);
        check(r == 1'b0, "R6 refresh ignored", int'(r), 0);

        // R7: gating without the lock
        do_reset(mk_cfg(1'b0, 2'd3, 1'b1, 3'd0, 1'b0));
        tick_run(127, first);
        halt_mode = 1'b1;    tick_run(20, first); halt_mode = 1'b0;
        check(first == 0, "R7 halt gates", first, 0);
        stop_mode = 1'b1;    tick_run(20, first); stop_mode = 1'b0;
        check(first == 0, "R7 stop gates", first, 0);
        osc_stop_req = 1'b1; tick_run(20, first); osc_stop_req = 1'b0;
        check(first == 0, "R7 stop request gates", first, 0);
        tick_run(1, first);
        check(first == 1, "R7 resumes", first, 1);

        // R8: lock set, low-power inputs ignored
        do_reset(mk_cfg(1'b0, 2'd3, 1'b1, 3'd0, 1'b1));
        halt_mode = 1'b1; tick_run(100, first); halt_mode = 1'b0;
        stop_mode = 1'b1; tick_run(27, first);
        osc_stop_req = 1'b1; tick_run(1, first);
        stop_mode = 1'b0; osc_stop_req = 1'b0;
        check(first == 1, "R8 all ticks counted", first, 1);

        // R1: byte change after sampling ignored
        do_reset(mk_cfg(1'b0, 2'd3, 1'b1, 3'd0, 1'b1));
        cfg_byte = mk_cfg(1'b1, 2'd0, 1'b0, 3'd6, 1'b0);
        tick_run(128, first);
        check(first == 128, "R1 late byte ignored", first, 128);
        check(!cfg_illegal, "R1 late byte flag", int'(cfg_illegal), 0);

        // R9: forbidden combination falls back
        do_reset(mk_cfg(1'b0, 2'd0, 1'b1, 3'd0, 1'b1));
        check(cfg_illegal, "R9 forbidden combo flag", int'(cfg_illegal), 1);
        tick_run(200, first);
        check(first == 0, "R9 fallback period", first, 0);
        do_refresh(r);
        check(r == 1'b0, "R9 fallback full window", int'(r), 0);

        // R9: reserved bit set
        do_reset(mk_cfg(1'b1, 2'd3, 1'b1, 3'd0, 1'b1));
        check(cfg_illegal, "R9 reserved bit flag", int'(cfg_illegal), 1);
        tick_run(200, first);
        check(first == 0, "R9 reserved bit fallback", first, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule